// File: doc/BRIEF.md
# Legacy PC Memory Region Decoder

This block routes every byte-sized physical access to one target. It covers the legacy low megabyte and the boot ROM window just under 4 GiB. One request port carries an address, a write flag and the processor's system-management-mode (SMM) flag. One registered response names the chosen target with a one-hot select and gives the offset that target should use. The response also carries an error flag and, for unanswerable reads, a flag that tells the data path to return 0xFF.

Several inputs steer the decision:
- Three SMRAM control bits together with the SMM flag decide who owns the 0xA0000–0xBFFFF window.
- A per-area table of shadow read and write enables governs 0xC0000–0xFFFFF.
- A programmable boot ROM base selects the top-of-4-GiB window.
- An installed-memory limit marks where DRAM ends.
- An A20 gate input masks address bit 20 before anything else is looked at.

The devices behind the targets and all data movement lie outside the block.

Top module: `legacy_mem_decoder`

## Requirements
- R1: After reset the response is idle (rsp_valid=0, rsp_sel=0, flags low) and the boot ROM base equals 0xFFFF0000.
- R2: A request sampled at a clock edge produces its response after that edge (one cycle of latency). A valid response has exactly one bit of rsp_sel set, and an idle cycle has none. The bit positions are: 0 DRAM, 1 SMRAM, 2 VGA/MMIO, 3 shadow DRAM, 4 expansion ROM, 5 boot ROM/flash, 6 dropped write, 7 error.
- R3: While a20_en is low, address bit 20 is treated as zero for decoding and for the offset.
- R4: An access in 0xA0000–0xBFFFF selects SMRAM when smram_avail is high and either smram_en is high or req_smm is high with smram_restrict low. With smram_avail low, the other two bits have no effect.
- R5: Every other access in 0xA0000–0xBFFFF selects VGA/MMIO, with offset equal to the address.
- R6: With shadow_on high, the area index in 0xC0000–0xFFFFF is address bits 17:14 clamped to 12. Area 12 therefore spans all of 0xF0000–0xFFFFF.
- R7: With shadow_on high, a read whose area read bit is set selects shadow DRAM (offset = address). When that bit is clear, the read goes to ROM. Reads in 0xE0000–0xFFFFF then select the boot ROM with offset (ROM size − 0x20000) + address[16:0]. Reads in 0xC0000–0xDFFFF select expansion ROM with offset address[16:0].
- R8: With shadow_on high, a write whose area write bit is set selects shadow DRAM. When that bit is clear, the write selects "dropped" with no error.
- R9: With shadow_on low, reads in 0xC0000–0xFFFFF follow the same ROM mapping as R7. Writes there select error with rsp_err high and rsp_ff low.
- R10: An address below 4 GiB and at or above the boot ROM base selects the boot ROM for reads, with offset equal to the address modulo the ROM size. Writes there are refused: they select error with rsp_err high. A base written through bios_base_we applies from the next request onward.
- R11: Any other address below mem_limit selects DRAM with offset equal to the address.
- R12: Any remaining access selects error with rsp_err high. rsp_ff is high for reads only.
- R13: Decode priority is fixed:
  1. A20 masking.
  2. The 0xA0000–0xBFFFF window.
  3. The 0xC0000–0xFFFFF window.
  4. The boot ROM window.
  5. DRAM.
  6. Error.

  Addresses at or above 4 GiB never count as boot ROM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a20_en | input | 1 | High passes address bit 20, low forces it to zero |
| smram_avail | input | 1 | SMRAM window is available |
| smram_en | input | 1 | SMRAM is open to all accesses |
| smram_restrict | input | 1 | SMM accesses may not use SMRAM unless smram_en is high |
| shadow_on | input | 1 | Shadow area table is in use |
| shadow_rd | input | 13 | Per-area read enable for shadow DRAM |
| shadow_wr | input | 13 | Per-area write enable for shadow DRAM |
| mem_limit | input | ADDR_W | First address above installed DRAM |
| bios_base_we | input | 1 | Load a new boot ROM base |
| bios_base_wdata | input | 32 | New boot ROM base |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | Request is a write |
| req_smm | input | 1 | Requester is in SMM |
| req_addr | input | ADDR_W | Physical byte address |
| rsp_valid | output | 1 | Response present |
| rsp_sel | output | 8 | One-hot target select |
| rsp_off | output | ADDR_W | Offset inside the selected target |
| rsp_err | output | 1 | Access could not be served |
| rsp_ff | output | 1 | Read data must be 0xFF |

## Verification
The bench uses the default build: ADDR_W=36 and ROM_LOG2=18. The 36-bit address lets requests at and beyond 4 GiB show that the boot ROM window stops there. The 256 KiB ROM makes the low-megabyte alias offset (0x20000 and up) differ from a plain address[16:0]. That difference exposes a wrong alias base. The bench also programs the boot ROM base low enough to overlap DRAM and the legacy windows, which exercises the priority chain directly.

// File: rtl/lmd_pkg.sv
package lmd_pkg;
    localparam int TGT_N     = 8;
    localparam int T_DRAM    = 0;
    localparam int T_SMRAM   = 1;
    localparam int T_VGA     = 2;
    localparam int T_SHADOW  = 3;
    localparam int T_XROM    = 4;
    localparam int T_BIOS    = 5;
    localparam int T_DROP    = 6;
    localparam int T_ERR     = 7;
    localparam int AREA_N    = 13;
    localparam int AREA_LAST = AREA_N - 1;
    localparam logic [31:0] BIOS_BASE_RST = 32'hFFFF_0000;
endpackage

// File: rtl/lmd_window_dec.sv
module lmd_window_dec #(
    parameter int ADDR_W = 36
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] mem_limit,
    input  logic [31:0]       bios_base,
    output logic              in_ab,
    output logic              in_cf,
    output logic              in_ef,
    output logic              in_bios,
    output logic              below_top
);
    logic low_meg;
    logic above4g;

    always_comb begin
        low_meg   = (addr[ADDR_W-1:20] == '0);
        in_ab     = low_meg && (addr[19:17] == 3'b101);
        in_cf     = low_meg && (addr[19:18] == 2'b11);
        in_ef     = low_meg && (addr[19:17] == 3'b111);
        above4g   = (addr[ADDR_W-1:32] != '0);
        in_bios   = !above4g && (addr[31:0] >= bios_base);
        below_top = (addr < mem_limit);
    end
endmodule

// File: rtl/lmd_area_sel.sv
module lmd_area_sel
    import lmd_pkg::*;
(
    input  logic [3:0]        idx,
    input  logic [AREA_N-1:0] rd_en,
    input  logic [AREA_N-1:0] wr_en,
    output logic              rd_shadow,
    output logic              wr_shadow
);
    localparam int SLOTS = 16;
    logic [SLOTS-1:0] rd_tab;
    logic [SLOTS-1:0] wr_tab;

    // Indices beyond the final area fold onto it.
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        localparam int SRC = (i < AREA_N) ? i : AREA_LAST;
        assign rd_tab[i] = rd_en[SRC];
        assign wr_tab[i] = wr_en[SRC];
    end

    assign rd_shadow = rd_tab[idx];
    assign wr_shadow = wr_tab[idx];
endmodule

// File: rtl/lmd_rom_map.sv
module lmd_rom_map #(
    parameter int ADDR_W   = 36,
    parameter int ROM_LOG2 = 18
) (
    input  logic [ROM_LOG2-1:0] rom_bits,
    output logic [ADDR_W-1:0]   bios_off,
    output logic [ADDR_W-1:0]   alias_off,
    output logic [ADDR_W-1:0]   xrom_off
);
    localparam int TOP_W = ROM_LOG2 - 17;

    assign bios_off = ADDR_W'(rom_bits);
    assign xrom_off = ADDR_W'(rom_bits[16:0]);

    // The low-megabyte ROM view sits on the last 128 KiB of the image.
    if (TOP_W > 0) begin : g_big_rom
        assign alias_off = ADDR_W'({{TOP_W{1'b1}}, rom_bits[16:0]});
    end else begin : g_small_rom
        assign alias_off = ADDR_W'(rom_bits[16:0]);
    end
endmodule

// File: rtl/legacy_mem_decoder.sv
module legacy_mem_decoder
    import lmd_pkg::*;
#(
    parameter int ADDR_W   = 36,
    parameter int ROM_LOG2 = 18
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                a20_en,
    input  logic                smram_avail,
    input  logic                smram_en,
    input  logic                smram_restrict,
    input  logic                shadow_on,
    input  logic [AREA_N-1:0]   shadow_rd,
    input  logic [AREA_N-1:0]   shadow_wr,
    input  logic [ADDR_W-1:0]   mem_limit,
    input  logic                bios_base_we,
    input  logic [31:0]         bios_base_wdata,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic                req_smm,
    input  logic [ADDR_W-1:0]   req_addr,
    output logic                rsp_valid,
    output logic [TGT_N-1:0]    rsp_sel,
    output logic [ADDR_W-1:0]   rsp_off,
    output logic                rsp_err,
    output logic                rsp_ff
);
    typedef struct packed {
        logic               valid;
        logic [TGT_N-1:0]   sel;
        logic [ADDR_W-1:0]  off;
        logic               err;
        logic               ff;
        logic [31:0]        base;
    } state_t;

    state_t st_d, st_q;

    logic [ADDR_W-1:0] addr_m;
    logic in_ab, in_cf, in_ef, in_bios, below_top;
    logic rd_shadow, wr_shadow;
    logic smram_hit;
    logic [ADDR_W-1:0] bios_off, alias_off, xrom_off;

    always_comb begin
        addr_m = req_addr;
        if (!a20_en) addr_m[20] = 1'b0;
    end

    lmd_window_dec #(.ADDR_W(ADDR_W)) win_i (
        .addr      (addr_m),
        .mem_limit (mem_limit),
        .bios_base (st_q.base),
        .in_ab     (in_ab),
        .in_cf     (in_cf),
        .in_ef     (in_ef),
        .in_bios   (in_bios),
        .below_top (below_top)
    );

    lmd_area_sel area_i (
        .idx       (addr_m[17:14]),
        .rd_en     (shadow_rd),
        .wr_en     (shadow_wr),
        .rd_shadow (rd_shadow),
        .wr_shadow (wr_shadow)
    );

    lmd_rom_map #(.ADDR_W(ADDR_W), .ROM_LOG2(ROM_LOG2)) rom_i (
        .rom_bits  (addr_m[ROM_LOG2-1:0]),
        .bios_off  (bios_off),
        .alias_off (alias_off),
        .xrom_off  (xrom_off)
    );

    assign smram_hit = smram_avail && (smram_en || (req_smm && !smram_restrict));

    always_comb begin
        int tgt;
        st_d       = st_q;
        st_d.valid = req_valid;
        st_d.sel   = '0;
        st_d.off   = addr_m;
        st_d.err   = 1'b0;
        st_d.ff    = 1'b0;
        tgt        = T_DRAM;
        if (bios_base_we) st_d.base = bios_base_wdata;

        if (in_ab) begin
            tgt = smram_hit ? T_SMRAM : T_VGA;
        end else if (in_cf) begin
            if (req_write) begin
                if (!shadow_on) begin
                    tgt      = T_ERR;
                    st_d.err = 1'b1;
                end else begin
                    tgt = wr_shadow ? T_SHADOW : T_DROP;
                end
            end else if (shadow_on && rd_shadow) begin
                tgt = T_SHADOW;
            end else if (in_ef) begin
                tgt      = T_BIOS;
                st_d.off = alias_off;
            end else begin
                tgt      = T_XROM;
                st_d.off = xrom_off;
            end
        end else if (in_bios) begin
            if (req_write) begin
                tgt      = T_ERR;
                st_d.err = 1'b1;
            end else begin
                tgt      = T_BIOS;
                st_d.off = bios_off;
            end
        end else if (below_top) begin
            tgt = T_DRAM;
        end else begin
            tgt      = T_ERR;
            st_d.err = 1'b1;
            st_d.ff  = !req_write;
        end

        if (req_valid) begin
            st_d.sel[tgt] = 1'b1;
        end else begin
            st_d.err = 1'b0;
            st_d.ff  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.base  <= BIOS_BASE_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.valid;
    assign rsp_sel   = st_q.sel;
    assign rsp_off   = st_q.off;
    assign rsp_err   = st_q.err;
    assign rsp_ff    = st_q.ff;
endmodule

// File: rtl/lmd_checker.sv
module lmd_checker
    import lmd_pkg::*;
#(
    parameter int ADDR_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smram_avail,
    input logic              shadow_on,
    input logic [AREA_N-1:0] shadow_wr,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic [TGT_N-1:0]  rsp_sel,
    input logic              rsp_err,
    input logic              rsp_ff
);
    localparam logic [ADDR_W-1:0] AREA0_TAG = ADDR_W'('h30);

    a_r2_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones(rsp_sel) == 1));

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_sel == '0 && !rsp_err && !rsp_ff));

    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r4_no_smram_unavail: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !smram_avail) |=> !rsp_sel[T_SMRAM]);

    a_r8_drop_area0: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && shadow_on && !shadow_wr[0]
         && ((req_addr >> 14) == AREA0_TAG)) |=> rsp_sel[T_DROP]);

    a_r12_write_no_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> !rsp_ff);

    a_r12_ff_is_error: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ff |-> (rsp_err && rsp_sel[T_ERR]));
endmodule

bind legacy_mem_decoder lmd_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .smram_avail (smram_avail),
    .shadow_on   (shadow_on),
    .shadow_wr   (shadow_wr),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .rsp_valid   (rsp_valid),
    .rsp_sel     (rsp_sel),
    .rsp_err     (rsp_err),
    .rsp_ff      (rsp_ff)
);

// File: tb/legacy_mem_decoder_tb_top.sv
module legacy_mem_decoder_tb_top;
    localparam int AW   = 36;
    localparam longint ROMB = 64'h40000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a20_en = 1'b1, smram_avail = 1'b0, smram_en = 1'b0, smram_restrict = 1'b0;
    logic shadow_on = 1'b0;
    logic [12:0] shadow_rd = '0, shadow_wr = '0;
    logic [AW-1:0] mem_limit = AW'(64'h800_0000);
    logic bios_base_we = 1'b0;
    logic [31:0] bios_base_wdata = '0;
    logic req_valid = 1'b0, req_write = 1'b0, req_smm = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic rsp_valid, rsp_err, rsp_ff;
    logic [7:0] rsp_sel;
    logic [AW-1:0] rsp_off;

    int checks = 0;
    int errors = 0;
    longint model_base = 64'hFFFF_0000;

    always #10 clk = ~clk;

    legacy_mem_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .a20_en(a20_en), .smram_avail(smram_avail),
        .smram_en(smram_en), .smram_restrict(smram_restrict), .shadow_on(shadow_on),
        .shadow_rd(shadow_rd), .shadow_wr(shadow_wr), .mem_limit(mem_limit),
        .bios_base_we(bios_base_we), .bios_base_wdata(bios_base_wdata),
        .req_valid(req_valid), .req_write(req_write), .req_smm(req_smm),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_sel(rsp_sel),
        .rsp_off(rsp_off), .rsp_err(rsp_err), .rsp_ff(rsp_ff)
    );

    // Drive one cycle at a falling edge, compare at the next falling edge.
    task automatic step(input string tag, input bit v, input bit w, input bit smm,
                        input longint a);
        longint am, off;
        int tsel, area;
        bit err, ff;
        bit [7:0] xsel;
        req_valid = v; req_write = w; req_smm = smm; req_addr = AW'(a);
        am = a20_en ? a : (a & ~64'h10_0000);
        off = am; err = 0; ff = 0; tsel = 0;
        if (am >= 64'hA0000 && am < 64'hC0000) begin
            tsel = (smram_avail && (smram_en || (smm && !smram_restrict))) ? 1 : 2;
        end else if (am >= 64'hC0000 && am < 64'h10_0000) begin
            area = int'((am - 64'hC0000) / 64'h4000);
            if (area > 12) area = 12;
            if (w) begin
                if (!shadow_on) begin tsel = 7; err = 1; end
                else tsel = shadow_wr[area] ? 3 : 6;
            end else if (shadow_on && shadow_rd[area]) tsel = 3;
            else if (am >= 64'hE0000) begin tsel = 5; off = ROMB - 64'h20000 + (am - 64'hE0000); end
            else begin tsel = 4; off = am - 64'hC0000; end
        end else if (am < 64'h1_0000_0000 && am >= model_base) begin
            if (w) begin tsel = 7; err = 1; end
            else begin tsel = 5; off = am % ROMB; end
        end else if (am < longint'(mem_limit)) begin
            tsel = 0;
        end else begin
            tsel = 7; err = 1; ff = !w;
        end
        xsel = v ? (8'b1 << tsel) : 8'b0;
        if (!v) begin err = 0; ff = 0; end
        if (bios_base_we) model_base = longint'(bios_base_wdata);
        @(negedge clk);
        checks++;
        if (rsp_valid !== v || rsp_sel !== xsel || rsp_err !== err || rsp_ff !== ff
            || (v && rsp_off !== AW'(off))) begin
            errors++;
            $display("FAIL %s: got valid=%0b sel=%b off=%h err=%0b ff=%0b, expected valid=%0b sel=%b off=%h err=%0b ff=%0b",
                     tag, rsp_valid, rsp_sel, rsp_off, rsp_err, rsp_ff, v, xsel, AW'(off), err, ff);
        end
    endtask

    initial begin
        #(20 * 5000);
        errors++; checks++;
        $display("FAIL watchdog: got running, expected finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state and base
        step("R1 idle after reset", 0, 0, 0, 0);
        step("R1 R10 reset base read", 1, 0, 0, 64'hFFFF_0010);
        step("R12 below reset base", 1, 0, 0, 64'hFFFE_FFFF);
        // R11 DRAM
        step("R11 dram read", 1, 0, 0, 64'h12345);
        step("R11 dram write", 1, 1, 0, 64'h1000);
        // R3 A20
        a20_en = 1'b0;
        step("R3 a20 masked", 1, 0, 0, 64'h11_2345);
        step("R3 R13 a20 into vga", 1, 0, 0, 64'h1A_0000);
        a20_en = 1'b1;
        step("R3 a20 open", 1, 0, 0, 64'h11_2345);
        // R4 R5 SMRAM
        smram_en = 1'b1; smram_avail = 1'b0;
        step("R4 unavailable ignores enable", 1, 0, 1, 64'hA8000);
        smram_avail = 1'b1;
        step("R4 enabled", 1, 1, 0, 64'hB0000);
        smram_en = 1'b0;
        step("R4 smm unrestricted", 1, 0, 1, 64'hA0000);
        step("R5 no smm", 1, 0, 0, 64'hA0000);
        smram_restrict = 1'b1;
        step("R5 smm restricted", 1, 0, 1, 64'hBFFFF);
        smram_avail = 1'b0; smram_restrict = 1'b0;
        // R6 R7 R8 shadow
        shadow_on = 1'b1;
        shadow_rd = 13'h1000 | 13'h0001;
        shadow_wr = 13'h0004;
        step("R7 read shadow area0", 1, 0, 0, 64'hC0010);
        step("R7 read xrom area1", 1, 0, 0, 64'hC4020);
        step("R7 read alias area10", 1, 0, 0, 64'hE8000);
        step("R6 clamp area15", 1, 0, 0, 64'hFC000);
        shadow_rd = 13'h0000;
        step("R6 R7 area12 rom alias", 1, 0, 0, 64'hF0000);
        step("R8 write shadow area2", 1, 1, 0, 64'hC8000);
        step("R8 write dropped area0", 1, 1, 0, 64'hC0000);
        step("R2 idle between", 0, 0, 0, 64'hC0000);
        // R9 shadow off
        shadow_on = 1'b0; shadow_rd = '1; shadow_wr = '1;
        step("R9 read xrom", 1, 0, 0, 64'hD0000);
        step("R9 write refused", 1, 1, 0, 64'hD0000);
        step("R9 read alias top", 1, 0, 0, 64'hFFFF0);
        // R10 boot window
        step("R10 write refused", 1, 1, 0, 64'hFFFF_FFF0);
        bios_base_we = 1'b1; bios_base_wdata = 32'hFFF0_0000;
        step("R10 same cycle uses old base", 1, 0, 0, 64'hFFF8_0000);
        bios_base_we = 1'b0;
        step("R10 new base", 1, 0, 0, 64'hFFF8_0000);
        // R13 above 4 GiB and priority
        step("R13 above 4g not rom", 1, 0, 0, 64'h1_FFFF_0000);
        mem_limit = AW'(64'h2_0000_0000);
        step("R13 R11 above 4g dram", 1, 0, 0, 64'h1_FFFF_0000);
        mem_limit = AW'(64'h800_0000);
        step("R12 write beyond memory", 1, 1, 0, 64'h1_0000_0000);
        bios_base_we = 1'b1; bios_base_wdata = 32'h0008_0000;
        step("R2 idle during base load", 0, 0, 0, 0);
        bios_base_we = 1'b0;
        step("R13 rom over dram", 1, 0, 0, 64'h90000);
        step("R13 vga over rom", 1, 0, 0, 64'hA0000);
        step("R13 legacy rom over boot window", 1, 0, 0, 64'hD4000);
        step("R2 final idle", 0, 0, 0, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule